// File: doc/BRIEF.md
# System Counter with Compare Interrupt

This block keeps a free-running 64-bit count of time for a chip and raises one interrupt when that count reaches a programmed deadline. The count advances once for every three cycles of the input clock. Software reads it as two 32-bit words at separate addresses. Because the words are read one at a time, software reads high, then low, then high again, and keeps the pair only when both high reads agree.

A single compare frame sits 0x10000 bytes above the counter frame. It holds a 52-bit deadline, split into a 32-bit low word and a 20-bit high word, plus a control word. The control word carries an enable bit, an interrupt mask bit and a read-only status bit. While the frame is enabled and the count is at or past the deadline, the status bit sets. The interrupt output follows status unless the mask bit is set. The only way to acknowledge is to write enable back to zero, which clears status and drops the interrupt on the same clock edge.

Software programs a one-shot event in four steps: disable the frame, read the count, write the deadline, then enable the frame again. A deadline written while the frame is enabled takes effect at once. A deadline that is already in the past fires right away.

Top module: `sysctr_top`

## Requirements
- R1: After reset the count reads 0, the control word reads 0 (enable 0, mask 0, status 0) and `irq_o` is 0. A reset applied mid-run returns the block to this state.
- R2: The count increments by exactly one every three clock cycles and never changes by any other amount, so 30 cycles always add exactly 10.
- R3: Count bits 31:0 read at byte address 0x8 and bits 63:32 at 0xC. When two reads of 0xC around a read of 0x8 agree, the three reads form one 64-bit value that never goes backwards, including across a carry out of the low word.
- R4: The deadline low word sits at 0x10020 and its high word at 0x10024; both read back what was written. The control word sits at 0x1002C, with enable at bit 0, mask at bit 1 and status at bit 2. One edge after the count is at or above the deadline while enable is 1, status becomes 1, and it never sets while the count is below. A deadline already in the past fires once the frame is enabled.
- R5: Writing the control word with bit 0 clear clears status and drops `irq_o` at that same clock edge.
- R6: Only bits 19:0 of the deadline high word are stored; bits 31:20 read as 0 and take no part in the comparison.
- R7: `irq_o` is a register equal to status AND enable AND NOT mask. Setting the mask drops `irq_o` but leaves status at 1, and clearing the mask raises `irq_o` again.
- R8: Reads of any other address return 0. Writes to the count addresses change nothing, and writes to bit 2 of the control word are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the count advances every third cycle |
| rst_n | input | 1 | Active-low reset (asynchronous assert) |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (17) | Byte address |
| bus_wdata | input | 32 | Write data, captured at the clock edge |
| bus_rdata | output | 32 | Read data for the current address in the same cycle; 0 when not selected |
| irq_o | output | 1 | Registered compare interrupt |

## Verification
The bench attacks the boundary between "count below deadline" and "count at deadline". A comparator built as an equality test, or one that is off by one, would either miss a deadline that is already in the past or fire one tick early. It runs a second instance that starts just below a carry out of the low word and checks the high-low-high read protocol across that carry; a counter that carried late into the high word would produce a pair that goes backwards. It also checks that acknowledge and mask act in the right cycles, that the upper bits of the high deadline word are dropped both on readback and in the comparison, and that writes to read-only places leave the count and status untouched.

// File: rtl/sysctr_pkg.sv
package sysctr_pkg;

    // Byte offsets of the register map
    localparam int unsigned OFF_CNT_LO  = 32'h0000_0008;
    localparam int unsigned OFF_CNT_HI  = 32'h0000_000C;
    localparam int unsigned OFF_FRAME   = 32'h0001_0000;
    localparam int unsigned OFF_CMP_LO  = OFF_FRAME + 32'h20;
    localparam int unsigned OFF_CMP_HI  = OFF_FRAME + 32'h24;
    localparam int unsigned OFF_CTRL    = OFF_FRAME + 32'h2C;

    // Control word bit positions (status read-only)
    localparam int unsigned CTRL_EN_BIT   = 0;
    localparam int unsigned CTRL_MASK_BIT = 1;
    localparam int unsigned CTRL_STAT_BIT = 2;

    // Packed so that the bit order equals the register layout
    typedef struct packed {
        logic status;
        logic mask;
        logic en;
    } ctrl_t;

endpackage

// File: rtl/sysctr_tick.sv
module sysctr_tick #(
    parameter int unsigned DIV = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);

    typedef struct packed {
        logic [DIV_W-1:0] phase;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.phase == LAST) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = (st_q.phase == LAST);

    // R2: two ticks are never adjacent when dividing by more than one
    generate
        if (DIV > 1) begin : g_gap
            p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o)
                else $error("tick asserted in consecutive cycles");
        end
    endgenerate

endmodule

// File: rtl/sysctr_count.sv
module sysctr_count #(
    parameter int unsigned CNT_W    = 64,
    parameter logic [63:0] CNT_INIT = 64'h0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o
);
    typedef struct packed {
        logic [CNT_W-1:0] value;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            st_d.value = st_q.value + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.value <= CNT_INIT[CNT_W-1:0];
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.value;

    // R2: the count only ever moves forward by one
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o != $past(cnt_o)) |-> (cnt_o == $past(cnt_o) + CNT_W'(1)))
        else $error("count jumped by more than one");

    // R2: the count moves exactly when a tick was seen
    p_count_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> (cnt_o != $past(cnt_o)))
        else $error("tick did not advance count");

endmodule

// File: rtl/sysctr_cmp_frame.sv
module sysctr_cmp_frame
    import sysctr_pkg::*;
#(
    parameter int unsigned CNT_W    = 64,
    parameter int unsigned CMP_HI_W = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CNT_W-1:0]    cnt_i,
    input  logic                wr_lo_i,
    input  logic                wr_hi_i,
    input  logic                wr_ctrl_i,
    input  logic [31:0]         wdata_i,
    output logic [31:0]         cmp_lo_o,
    output logic [CMP_HI_W-1:0] cmp_hi_o,
    output ctrl_t               ctrl_o,
    output logic                irq_o
);
    localparam int unsigned CMP_W = 32 + CMP_HI_W;

    typedef struct packed {
        logic [31:0]         cmp_lo;
        logic [CMP_HI_W-1:0] cmp_hi;
        ctrl_t               ctrl;
        logic                irq;
    } frame_st_t;

    frame_st_t st_d, st_q;
    logic [CNT_W-1:0] deadline;
    logic             reached;

    assign deadline = CNT_W'({st_q.cmp_hi, st_q.cmp_lo});
    assign reached  = (cnt_i >= deadline);

    always_comb begin
        st_d = st_q;
        if (wr_lo_i) begin
            st_d.cmp_lo = wdata_i;
        end
        if (wr_hi_i) begin
            st_d.cmp_hi = wdata_i[CMP_HI_W-1:0];
        end
        if (st_q.ctrl.en && reached) begin
            st_d.ctrl.status = 1'b1;
        end
        if (wr_ctrl_i) begin
            st_d.ctrl.en   = wdata_i[CTRL_EN_BIT];
            st_d.ctrl.mask = wdata_i[CTRL_MASK_BIT];
            if (!wdata_i[CTRL_EN_BIT]) begin
                st_d.ctrl.status = 1'b0;
            end
        end
        st_d.irq = st_d.ctrl.status & st_d.ctrl.en & ~st_d.ctrl.mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp_lo_o = st_q.cmp_lo;
    assign cmp_hi_o = st_q.cmp_hi;
    assign ctrl_o   = st_q.ctrl;
    assign irq_o    = st_q.irq;

    // R4: an enabled frame that has reached its deadline shows status next cycle
    p_status_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o.en && reached && !wr_ctrl_i) |=> ctrl_o.status)
        else $error("status failed to set at deadline");

    // R4: status never rises while the count is below the deadline
    p_no_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_o.status) |-> $past(reached))
        else $error("status rose before deadline");

    // R5: writing enable low acknowledges on that edge
    p_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl_i && !wdata_i[CTRL_EN_BIT]) |=> (!ctrl_o.status && !irq_o))
        else $error("acknowledge did not clear status/irq");

    // R7: a masked frame never drives the interrupt
    p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_o.mask |-> !irq_o)
        else $error("irq asserted while masked");

    // R7: interrupt implies latched status
    p_irq_needs_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ctrl_o.status && ctrl_o.en))
        else $error("irq without status");

endmodule

// File: rtl/sysctr_top.sv
module sysctr_top
    import sysctr_pkg::*;
#(
    parameter int unsigned ADDR_W   = 17,
    parameter int unsigned CNT_W    = 64,
    parameter int unsigned CMP_HI_W = 20,
    parameter int unsigned DIV      = 3,
    parameter logic [63:0] CNT_INIT = 64'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'(OFF_CNT_LO);
    localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(OFF_CNT_HI);
    localparam logic [ADDR_W-1:0] A_CMP_LO = ADDR_W'(OFF_CMP_LO);
    localparam logic [ADDR_W-1:0] A_CMP_HI = ADDR_W'(OFF_CMP_HI);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);

    logic              tick;
    logic [CNT_W-1:0]  cnt;
    logic [63:0]       cnt64;
    logic              wr_lo, wr_hi, wr_ctrl;
    logic [31:0]       cmp_lo;
    logic [CMP_HI_W-1:0] cmp_hi;
    ctrl_t             ctrl;

    sysctr_tick #(.DIV(DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    sysctr_count #(.CNT_W(CNT_W), .CNT_INIT(CNT_INIT)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .cnt_o  (cnt)
    );

    assign cnt64 = 64'(cnt);

    assign wr_lo   = bus_sel && bus_wr && (bus_addr == A_CMP_LO);
    assign wr_hi   = bus_sel && bus_wr && (bus_addr == A_CMP_HI);
    assign wr_ctrl = bus_sel && bus_wr && (bus_addr == A_CTRL);

    sysctr_cmp_frame #(.CNT_W(CNT_W), .CMP_HI_W(CMP_HI_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_i     (cnt),
        .wr_lo_i   (wr_lo),
        .wr_hi_i   (wr_hi),
        .wr_ctrl_i (wr_ctrl),
        .wdata_i   (bus_wdata),
        .cmp_lo_o  (cmp_lo),
        .cmp_hi_o  (cmp_hi),
        .ctrl_o    (ctrl),
        .irq_o     (irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (bus_addr == A_CNT_LO) begin
                bus_rdata = cnt64[31:0];
            end else if (bus_addr == A_CNT_HI) begin
                bus_rdata = cnt64[63:32];
            end else if (bus_addr == A_CMP_LO) begin
                bus_rdata = cmp_lo;
            end else if (bus_addr == A_CMP_HI) begin
                bus_rdata = 32'(cmp_hi);
            end else if (bus_addr == A_CTRL) begin
                bus_rdata = 32'(ctrl);
            end
        end
    end

    // R6: the high deadline word never shows bits above its stored width
    p_hi_narrow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == A_CMP_HI) |-> (bus_rdata[31:CMP_HI_W] == '0))
        else $error("deadline high word shows upper bits");

    // R8: unmapped reads return zero
    p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr != A_CNT_LO && bus_addr != A_CNT_HI &&
         bus_addr != A_CMP_LO && bus_addr != A_CMP_HI && bus_addr != A_CTRL)
        |-> (bus_rdata == 32'h0))
        else $error("unmapped read nonzero");

endmodule

// File: tb/sysctr_top_test.sv
module sysctr_top_test;
    localparam int unsigned AW = 17;
    localparam logic [AW-1:0] CNT_LO = 17'h0_0008;
    localparam logic [AW-1:0] CNT_HI = 17'h0_000C;
    localparam logic [AW-1:0] CMP_LO = 17'h1_0020;
    localparam logic [AW-1:0] CMP_HI = 17'h1_0024;
    localparam logic [AW-1:0] CTRL   = 17'h1_002C;
    localparam logic [63:0]   WRAP_START = 64'h0000_0001_FFFF_FFD0;

    typedef struct packed {
        logic          wr;
        logic [AW-1:0] addr;
        logic [31:0]   data;   // write data or expected read data
        logic [3:0]    req;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, CMP_LO, 32'hDEAD_BEEF, 4'd4},
        '{1'b0, CMP_LO, 32'hDEAD_BEEF, 4'd4},
        '{1'b1, CMP_HI, 32'hFFF1_2345, 4'd6},
        '{1'b0, CMP_HI, 32'h0001_2345, 4'd6},
        '{1'b1, CTRL,   32'h0000_0006, 4'd8},
        '{1'b0, CTRL,   32'h0000_0002, 4'd8},
        '{1'b1, CTRL,   32'h0000_0000, 4'd8},
        '{1'b0, CTRL,   32'h0000_0000, 4'd8},
        '{1'b0, 17'h0_0004, 32'h0, 4'd8},
        '{1'b0, 17'h1_0000, 32'h0, 4'd8},
        '{1'b0, 17'h1_000C, 32'h0, 4'd8},
        '{1'b0, 17'h1_0028, 32'h0, 4'd8},
        '{1'b1, CMP_HI, 32'h0000_0001, 4'd4},
        '{1'b0, CMP_HI, 32'h0000_0001, 4'd4}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   rdata, rdata_w;
    logic          irq, irq_w;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sysctr_top uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata), .irq_o(irq)
    );

    sysctr_top #(.CNT_INIT(WRAP_START)) uut_wrap (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_w), .irq_o(irq_w)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d, output logic [31:0] dw);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = rdata; dw = rdata_w;
    endtask

    task automatic wrt(input logic [AW-1:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_sel = 1'b0; bus_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, dw, a, b, h1, h2, lo, c;
        logic [63:0] prev, v;
        bit early, late, seen, saw_carry;

        // R1: reset state, sampled while reset is still low
        repeat (2) @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = CNT_LO; #1;
        check("R1 count lo", rdata, 0);
        bus_addr = CNT_HI; #1;
        check("R1 count hi", rdata, 0);
        bus_addr = CTRL; #1;
        check("R1 ctrl", rdata, 0);
        check("R1 irq", irq, 0);
        bus_sel = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R3: high-low-high protocol across a carry out of the low word
        prev = WRAP_START;
        saw_carry = 1'b0;
        for (int i = 0; i < 120; i++) begin
            rd(CNT_HI, d, h1);
            rd(CNT_LO, d, lo);
            rd(CNT_HI, d, h2);
            if (h1 == h2) begin
                v = {h1, lo};
                check("R3 pair not backwards", 64'(v >= prev), 1);
                check("R3 pair bounded", 64'(v <= prev + 64'd4), 1);
                prev = v;
                if (h1 == 32'h2) saw_carry = 1'b1;
            end
        end
        check("R3 carry reached high word", 64'(saw_carry), 1);

        // R2: exactly ten increments across thirty cycles
        rd(CNT_LO, a, dw);
        repeat (29) @(negedge clk);
        rd(CNT_LO, b, dw);
        check("R2 rate", b - a, 10);

        // Vector table: register map behaviour
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i].wr) begin
                wrt(VEC[i].addr, VEC[i].data);
            end else begin
                rd(VEC[i].addr, d, dw);
                check($sformatf("R%0d table vector %0d", VEC[i].req, i), d, VEC[i].data);
            end
        end
        check("R7 irq idle after table", irq, 0);

        // R8: writes to the count are ignored
        rd(CNT_LO, a, dw);
        wrt(CNT_LO, 32'hFFFF_0000);
        wrt(CNT_HI, 32'h1234_5678);
        rd(CNT_LO, b, dw);
        check("R8 count write ignored", 64'((b >= a) && (b - a < 8)), 1);
        rd(CNT_HI, d, dw);
        check("R8 count hi write ignored", d, 0);

        // R4: deadline in the future fires at, never before, the deadline
        wrt(CMP_HI, 32'h0);
        rd(CNT_LO, c, dw);
        c = c + 32'd12;
        wrt(CMP_LO, c);
        wrt(CTRL, 32'h1);
        check("R4 no irq just after enable", irq, 0);
        early = 1'b0; late = 1'b0; seen = 1'b0;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = CNT_LO;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk); #1;
            if (irq && rdata < c) early = 1'b1;
            if (!irq && rdata > c) late = 1'b1;
            if (irq) seen = 1'b1;
        end
        check("R4 not early", 64'(early), 0);
        check("R4 not late", 64'(late), 0);
        check("R4 fired", 64'(seen), 1);
        rd(CTRL, d, dw);
        check("R4 status bit2 set", d, 32'h5);

        // R7: mask hides irq but keeps status
        wrt(CTRL, 32'h3);
        check("R7 masked irq", irq, 0);
        rd(CTRL, d, dw);
        check("R7 status kept under mask", d, 32'h7);
        wrt(CTRL, 32'h1);
        check("R7 unmask reasserts", irq, 1);

        // R5: acknowledge by clearing enable, effective on that edge
        wrt(CTRL, 32'h0);
        check("R5 irq dropped", irq, 0);
        rd(CTRL, d, dw);
        check("R5 status cleared", d, 0);

        // R4: a deadline in the past fires immediately once enabled
        wrt(CMP_LO, 32'h0);
        wrt(CTRL, 32'h1);
        check("R4 past: status not before next edge", irq, 0);
        @(negedge clk); #1;
        check("R4 past deadline fires", irq, 1);
        wrt(CTRL, 32'h0);

        // R6: upper bits of the high word take no part in the compare
        wrt(CMP_HI, 32'hFFF0_0000);
        wrt(CMP_LO, 32'h0);
        wrt(CTRL, 32'h1);
        @(negedge clk); #1;
        check("R6 upper bits ignored in compare", irq, 1);

        // R1: mid-run reset returns to idle
        do_reset();
        #1;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = CTRL; #1;
        check("R1 ctrl after mid-run reset", rdata, 0);
        check("R1 irq after mid-run reset", irq, 0);
        bus_addr = CMP_HI; #1;
        check("R1 deadline high after reset", rdata, 0);
        bus_sel = 1'b0;

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule